// File: doc/BRIEF.md
# Bufferless Deflection Router Node

This block is one node of a two-dimensional mesh network on chip. Four neighbour links (north, east, south, west) feed flits in, and a local port both injects new flits and ejects flits that have reached this node. The router stores no flits. Any flit that arrives in a cycle is sent out on some output link two clock edges later. When several flits want the same link, the oldest one gets it. Each of the others is pushed onto whatever link is still free, even when that link leads away from its destination.

The work is split over two register stages. The first stage ages every arriving flit by one hop, computes its productive direction with X-then-Y routing against the node's strapped coordinates, and ranks all candidates by age. The second stage walks the candidates in rank order. Each one claims its productive port if that port is still free, and otherwise it is force-scheduled onto the lowest-numbered free network port. The result is captured in the output registers. The local source gets a same-cycle accept signal that tells it whether its flit was taken in that cycle.

Top module: `deflect_router`

## Requirements
- R1: While rst_n is low at a clock edge, every network output valid and the eject valid read 0 after that edge.
- R2: Every flit on a valid network input and every accepted injected flit leaves exactly once, on the output registers two rising edges after it was presented. The number of valid outputs in that cycle equals the number of flits admitted.
- R3: The flit bit layout is payload [31:0], age [39:32], destination x [41:40] and destination y [43:42]. A flit from a network input leaves with age+1, saturating at 255. An injected flit leaves with age 0. All other fields are unchanged.
- R4: The productive port is chosen by comparing X first. Destination x greater than node x gives east and smaller gives west. When x is equal, destination y greater than node y gives north and smaller gives south. When both are equal the port is local (eject).
- R5: Candidates are served in order of decreasing outgoing age. Equal ages are served by lower input index: north=0, east=1, south=2, west=3, injection=4.
- R6: In service order, each flit takes its productive port if no earlier flit holds it. Otherwise it takes the lowest-numbered free network output (north=0, east=1, south=2, west=3). Each output carries at most one flit.
- R7: At most one flit is ejected per cycle, and only a flit addressed to this node is ejected. A second flit addressed here is deflected onto a network output.
- R8: inj_accept is high in the same cycle exactly when inj_valid is high and either fewer than four network inputs are valid or at least one valid network input is addressed to this node. A refused flit never appears at any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_x | input | 2 | Strapped x coordinate of this node |
| node_y | input | 2 | Strapped y coordinate of this node |
| net_in_valid | input | 4 | Valid per incoming link, index N,E,S,W |
| net_in_flit | input | 4x44 | Flit per incoming link |
| inj_valid | input | 1 | Local source offers a flit |
| inj_flit | input | 44 | Flit offered by the local source |
| inj_accept | output | 1 | Offered flit taken this cycle |
| net_out_valid | output | 4 | Registered valid per outgoing link, index N,E,S,W |
| net_out_flit | output | 4x44 | Registered flit per outgoing link |
| ej_valid | output | 1 | Registered valid of the eject port |
| ej_flit | output | 44 | Flit ejected to the local sink |

## Verification
The bench uses the default build: 2-bit coordinates (a 4x4 mesh) and 8-bit ages. It moves the node straps through all sixteen positions, so that every X/Y direction and every mesh edge or corner relation is reached. At each position it steps through all 32 occupancy masks of the four links plus injection. Ages are drawn from a handful of small values so that ties are frequent, and from values near 255 so that saturation is reached. Directed vectors then cover the full-load injection refusal, double ejection and tie ordering.

// File: rtl/defl_pkg.sv
// Package: shared widths, port indices and the flit layout of the
// deflection router. Assumes a 2D mesh with one local port.
package defl_pkg;
    localparam int COORD_W  = 2;
    localparam int AGE_W    = 8;
    localparam int DATA_W   = 32;
    localparam int NUM_NET  = 4;
    localparam int NUM_SLOT = NUM_NET + 1;
    localparam int RANK_W   = $clog2(NUM_SLOT);
    localparam int CNT_W    = $clog2(NUM_NET + 1);

    localparam int PORT_N = 0;
    localparam int PORT_E = 1;
    localparam int PORT_S = 2;
    localparam int PORT_W = 3;
    localparam int PORT_L = 4;

    typedef struct packed {
        logic [COORD_W-1:0] dy;
        logic [COORD_W-1:0] dx;
        logic [AGE_W-1:0]   age;
        logic [DATA_W-1:0]  data;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);
endpackage

// File: rtl/defl_xy_route.sv
// Module: productive-port selection by X-then-Y dimension order.
// Output is one-hot over N,E,S,W,Local. Assumes y grows toward north.
module defl_xy_route
    import defl_pkg::*;
(
    input  logic [COORD_W-1:0]  here_x,
    input  logic [COORD_W-1:0]  here_y,
    input  logic [COORD_W-1:0]  dest_x,
    input  logic [COORD_W-1:0]  dest_y,
    output logic [NUM_SLOT-1:0] want
);
    // pick the single productive direction
    always_comb begin
        want = '0;
        if (dest_x > here_x)      want[PORT_E] = 1'b1;
        else if (dest_x < here_x) want[PORT_W] = 1'b1;
        else if (dest_y > here_y) want[PORT_N] = 1'b1;
        else if (dest_y < here_y) want[PORT_S] = 1'b1;
        else                      want[PORT_L] = 1'b1;
    end
endmodule

// File: rtl/defl_rank_stage.sv
// Module: pipeline stage one. Ages each candidate by one hop (saturating),
// resets the age of the injected candidate, computes productive ports and
// a unique service rank (0 = served first), then registers all of it.
// Assumes slot NUM_NET is the local injection slot.
module defl_rank_stage
    import defl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COORD_W-1:0]  here_x,
    input  logic [COORD_W-1:0]  here_y,
    input  logic [NUM_SLOT-1:0] cand_valid,
    input  flit_t               cand_flit [NUM_SLOT],
    output logic [NUM_SLOT-1:0] s1_valid,
    output flit_t               s1_flit   [NUM_SLOT],
    output logic [NUM_SLOT-1:0] s1_want   [NUM_SLOT],
    output logic [RANK_W-1:0]   s1_rank   [NUM_SLOT]
);
    flit_t               aged   [NUM_SLOT];
    logic [NUM_SLOT-1:0] want_d [NUM_SLOT];
    logic [RANK_W-1:0]   rank_d [NUM_SLOT];

    function automatic logic beats(input logic vi, input logic vj,
                                   input logic [AGE_W-1:0] ai,
                                   input logic [AGE_W-1:0] aj,
                                   input int i, input int j);
        return vi && (!vj || (ai > aj) || ((ai == aj) && (i < j)));
    endfunction

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_route
        defl_xy_route u_route (
            .here_x (here_x),
            .here_y (here_y),
            .dest_x (cand_flit[g].dx),
            .dest_y (cand_flit[g].dy),
            .want   (want_d[g])
        );
    end

    // hop-count the ages: saturate transit flits, zero the injected one
    always_comb begin
        for (int i = 0; i < NUM_SLOT; i++) begin
            aged[i] = cand_flit[i];
            if (i < NUM_NET) begin
                if (cand_flit[i].age != '1)
                    aged[i].age = cand_flit[i].age + AGE_W'(1);
            end else begin
                aged[i].age = '0;
            end
        end
    end

    // rank = number of candidates that beat this one
    always_comb begin
        for (int j = 0; j < NUM_SLOT; j++) begin
            logic [RANK_W-1:0] cnt;
            cnt = '0;
            for (int i = 0; i < NUM_SLOT; i++) begin
                if (i != j && beats(cand_valid[i], cand_valid[j],
                                    aged[i].age, aged[j].age, i, j))
                    cnt = cnt + RANK_W'(1);
            end
            rank_d[j] = cnt;
        end
    end

    // stage-one pipeline registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= '0;
            for (int i = 0; i < NUM_SLOT; i++) begin
                s1_flit[i] <= '0;
                s1_want[i] <= '0;
                s1_rank[i] <= '0;
            end
        end else begin
            s1_valid <= cand_valid;
            for (int i = 0; i < NUM_SLOT; i++) begin
                s1_flit[i] <= aged[i];
                s1_want[i] <= want_d[i];
                s1_rank[i] <= rank_d[i];
            end
        end
    end

    for (genvar a = 0; a < NUM_SLOT; a++) begin : g_pa
        for (genvar b = 0; b < NUM_SLOT; b++) begin : g_pb
            if (a < b) begin : g_lt
                // R5
                older_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (s1_valid[a] && s1_valid[b] && (s1_flit[a].age >= s1_flit[b].age))
                    |-> (s1_rank[a] < s1_rank[b]));
            end else if (a > b) begin : g_gt
                // R5
                strict_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (s1_valid[a] && s1_valid[b] && (s1_flit[a].age > s1_flit[b].age))
                    |-> (s1_rank[a] < s1_rank[b]));
            end
        end
    end
endmodule

// File: rtl/defl_alloc_stage.sv
// Module: pipeline stage two. Serves candidates in rank order: productive
// port if free, else the lowest free network port (force schedule), then
// registers the crossbar result. Assumes admission already guaranteed that
// a free network port exists for every non-ejecting candidate.
module defl_alloc_stage
    import defl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SLOT-1:0] s1_valid,
    input  flit_t               s1_flit [NUM_SLOT],
    input  logic [NUM_SLOT-1:0] s1_want [NUM_SLOT],
    input  logic [RANK_W-1:0]   s1_rank [NUM_SLOT],
    output logic [NUM_SLOT-1:0] port_valid,
    output flit_t               port_flit [NUM_SLOT]
);
    logic [NUM_SLOT-1:0] grant [NUM_SLOT];
    logic [NUM_SLOT-1:0] col   [NUM_SLOT];
    logic [NUM_SLOT-1:0] nxt_valid;
    flit_t               nxt_flit [NUM_SLOT];

    // rank-ordered port claim with forced fallback
    always_comb begin
        logic [NUM_SLOT-1:0] taken;
        logic [NUM_SLOT-1:0] alt;
        taken = '0;
        alt   = '0;
        for (int s = 0; s < NUM_SLOT; s++) grant[s] = '0;
        for (int r = 0; r < NUM_SLOT; r++) begin
            for (int s = 0; s < NUM_SLOT; s++) begin
                if (s1_valid[s] && (s1_rank[s] == RANK_W'(r))) begin
                    if ((s1_want[s] & ~taken) != '0) begin
                        grant[s] = s1_want[s];
                    end else begin
                        alt = '0;
                        for (int p = NUM_NET - 1; p >= 0; p--) begin
                            if (!taken[p]) begin
                                alt    = '0;
                                alt[p] = 1'b1;
                            end
                        end
                        grant[s] = alt;
                    end
                    taken = taken | grant[s];
                end
            end
        end
    end

    // crossbar: route each granted flit to its output
    always_comb begin
        for (int p = 0; p < NUM_SLOT; p++) begin
            nxt_valid[p] = 1'b0;
            nxt_flit[p]  = '0;
            for (int s = 0; s < NUM_SLOT; s++) begin
                col[p][s] = grant[s][p];
                if (grant[s][p]) begin
                    nxt_valid[p] = 1'b1;
                    nxt_flit[p]  = s1_flit[s];
                end
            end
        end
    end

    // output link registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_valid <= '0;
            for (int p = 0; p < NUM_SLOT; p++) port_flit[p] <= '0;
        end else begin
            port_valid <= nxt_valid;
            for (int p = 0; p < NUM_SLOT; p++) port_flit[p] <= nxt_flit[p];
        end
    end

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot_chk
        // R2
        every_flit_placed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s1_valid[s] |-> ($countones(grant[s]) == 1));
        // R7
        eject_only_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[s][PORT_L] |-> s1_want[s][PORT_L]);
        // R6
        winner_productive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_valid[s] && (s1_rank[s] == '0)) |-> (grant[s] == s1_want[s]));
    end

    for (genvar p = 0; p < NUM_SLOT; p++) begin : g_port_chk
        // R6
        one_per_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[p]));
    end

    // R2
    flit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(port_valid) == $past($countones(s1_valid))));
endmodule

// File: rtl/deflect_router.sv
// Module: top of the bufferless deflection router node. Decides local
// injection admission, then runs the rank stage and the allocation stage.
// Assumes links at a mesh edge are looped back outside this block, so a
// deflection onto them is never lost.
module deflect_router
    import defl_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [COORD_W-1:0]               node_x,
    input  logic [COORD_W-1:0]               node_y,
    input  logic [NUM_NET-1:0]               net_in_valid,
    input  logic [NUM_NET-1:0][FLIT_W-1:0]   net_in_flit,
    input  logic                             inj_valid,
    input  logic [FLIT_W-1:0]                inj_flit,
    output logic                             inj_accept,
    output logic [NUM_NET-1:0]               net_out_valid,
    output logic [NUM_NET-1:0][FLIT_W-1:0]   net_out_flit,
    output logic                             ej_valid,
    output logic [FLIT_W-1:0]                ej_flit
);
    flit_t               cand_flit [NUM_SLOT];
    logic [NUM_SLOT-1:0] cand_valid;
    logic [CNT_W-1:0]    n_busy;
    logic                local_hit;
    logic                room;

    logic [NUM_SLOT-1:0] s1_valid;
    flit_t               s1_flit [NUM_SLOT];
    logic [NUM_SLOT-1:0] s1_want [NUM_SLOT];
    logic [RANK_W-1:0]   s1_rank [NUM_SLOT];
    logic [NUM_SLOT-1:0] port_valid;
    flit_t               port_flit [NUM_SLOT];

    // unpack link inputs into candidate slots
    always_comb begin
        for (int i = 0; i < NUM_NET; i++) cand_flit[i] = flit_t'(net_in_flit[i]);
        cand_flit[NUM_NET] = flit_t'(inj_flit);
    end

    // admission: a free network link must remain after transit flits
    always_comb begin
        n_busy    = '0;
        local_hit = 1'b0;
        for (int i = 0; i < NUM_NET; i++) begin
            if (net_in_valid[i]) begin
                n_busy = n_busy + CNT_W'(1);
                if (cand_flit[i].dx == node_x && cand_flit[i].dy == node_y)
                    local_hit = 1'b1;
            end
        end
        room = (n_busy < CNT_W'(NUM_NET)) || local_hit;
    end

    assign inj_accept = inj_valid && room;
    assign cand_valid = {inj_accept, net_in_valid};

    defl_rank_stage u_rank (
        .clk        (clk),
        .rst_n      (rst_n),
        .here_x     (node_x),
        .here_y     (node_y),
        .cand_valid (cand_valid),
        .cand_flit  (cand_flit),
        .s1_valid   (s1_valid),
        .s1_flit    (s1_flit),
        .s1_want    (s1_want),
        .s1_rank    (s1_rank)
    );

    defl_alloc_stage u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_flit    (s1_flit),
        .s1_want    (s1_want),
        .s1_rank    (s1_rank),
        .port_valid (port_valid),
        .port_flit  (port_flit)
    );

    // drive the link outputs from the registered crossbar
    always_comb begin
        for (int i = 0; i < NUM_NET; i++) net_out_flit[i] = port_flit[i];
    end
    assign net_out_valid = port_valid[NUM_NET-1:0];
    assign ej_valid      = port_valid[PORT_L];
    assign ej_flit       = port_flit[PORT_L];
endmodule

// File: tb/deflect_router_test.sv
`timescale 1ns/1ps
module deflect_router_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] nx = 2'd1, ny = 2'd2;
    logic [3:0] iv = '0;
    logic [3:0][43:0] ifl = '0;
    logic jv = 1'b0;
    logic [43:0] jf = '0;
    logic inj_accept;
    logic [3:0] net_out_valid;
    logic [3:0][43:0] net_out_flit;
    logic ej_valid;
    logic [43:0] ej_flit;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int unsigned rs = 32'h1234_5678;

    logic [4:0]  rv [4];
    logic [43:0] rf [4][5];
    int          rc [4];
    string       rt [4];
    bit          live [4];

    always #2 clk = ~clk;

    deflect_router uut (
        .clk(clk), .rst_n(rst_n), .node_x(nx), .node_y(ny),
        .net_in_valid(iv), .net_in_flit(ifl), .inj_valid(jv), .inj_flit(jf),
        .inj_accept(inj_accept), .net_out_valid(net_out_valid),
        .net_out_flit(net_out_flit), .ej_valid(ej_valid), .ej_flit(ej_flit)
    );

    function automatic logic [43:0] mk(int dx, int dy, int age, int data);
        return {2'(dy), 2'(dx), 8'(age), 32'(data)};
    endfunction

    function automatic int unsigned nxt_rand();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // model of R3..R8: expected outputs of the current inputs
    task automatic predict(input int idx, input string tag);
        logic [43:0] f [5];
        bit v [5];
        int ag [5];
        int wp [5];
        bit picked [5];
        bit tk [5];
        int nbusy;
        bit hit;
        bit acc;
        int best;
        int p;
        int dx;
        int dy;
        nbusy = 0;
        hit = 0;
        for (int i = 0; i < 4; i++) begin
            if (iv[i]) begin
                nbusy++;
                if (ifl[i][41:40] == nx && ifl[i][43:42] == ny) hit = 1;
            end
        end
        acc = jv && (nbusy < 4 || hit);
        check("R8", "inj_accept", inj_accept, acc);
        for (int i = 0; i < 4; i++) begin
            v[i] = iv[i];
            f[i] = ifl[i];
            ag[i] = int'(ifl[i][39:32]) + 1;
            if (ag[i] > 255) ag[i] = 255;
            f[i][39:32] = 8'(ag[i]);
        end
        v[4] = acc;
        f[4] = jf;
        f[4][39:32] = 8'd0;
        ag[4] = 0;
        for (int i = 0; i < 5; i++) begin
            dx = int'(f[i][41:40]);
            dy = int'(f[i][43:42]);
            if (dx > int'(nx)) wp[i] = 1;
            else if (dx < int'(nx)) wp[i] = 3;
            else if (dy > int'(ny)) wp[i] = 0;
            else if (dy < int'(ny)) wp[i] = 2;
            else wp[i] = 4;
            picked[i] = 0;
            tk[i] = 0;
            rf[idx][i] = '0;
        end
        rv[idx] = '0;
        rc[idx] = 0;
        for (int i = 0; i < 5; i++) if (v[i]) rc[idx]++;
        for (int step = 0; step < 5; step++) begin
            best = -1;
            for (int i = 0; i < 5; i++)
                if (v[i] && !picked[i] && (best < 0 || ag[i] > ag[best])) best = i;
            if (best >= 0) begin
                picked[best] = 1;
                p = wp[best];
                if (tk[p]) begin
                    p = -1;
                    for (int q = 0; q < 4; q++) if (p < 0 && !tk[q]) p = q;
                end
                if (p >= 0) begin
                    tk[p] = 1;
                    rv[idx][p] = 1'b1;
                    rf[idx][p] = f[best];
                end
            end
        end
        live[idx] = 1;
        rt[idx] = tag;
    endtask

    task automatic compare(input int idx);
        int cnt;
        cnt = 0;
        for (int p = 0; p < 4; p++) begin
            check(rt[idx], $sformatf("link %0d valid", p), net_out_valid[p], rv[idx][p]);
            if (rv[idx][p]) check("R3", $sformatf("link %0d flit", p), net_out_flit[p], rf[idx][p]);
            if (net_out_valid[p]) cnt++;
        end
        check(rt[idx] == "R6" ? "R7" : rt[idx], "eject valid", ej_valid, rv[idx][4]);
        if (rv[idx][4]) check("R3", "eject flit", ej_flit, rf[idx][4]);
        if (ej_valid) cnt++;
        check("R2", "flit count", cnt, rc[idx]);
        live[idx] = 0;
    endtask

    // one cycle: predict inputs now on the bench, advance, check 2 back
    task automatic tick(input string tag);
        #1;
        predict(cyc % 4, tag);
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (live[(cyc + 2) % 4]) compare((cyc + 2) % 4);
    endtask

    task automatic idle(input int n);
        iv = '0;
        jv = 1'b0;
        for (int k = 0; k < n; k++) tick("R2");
    endtask

    function automatic int pick_age(int unsigned r);
        case (r % 7)
            0, 1, 2: return int'(r % 3);
            3:       return 5;
            4:       return 253;
            5:       return 254;
            default: return 255;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 4; i++) live[i] = 0;
        // R1: load traffic while reset is held
        iv = 4'hF;
        for (int i = 0; i < 4; i++) ifl[i] = mk(3, 3, 1, i);
        jv = 1'b1;
        jf = mk(0, 0, 0, 99);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "net valid in reset", net_out_valid, 4'h0);
        check("R1", "eject valid in reset", ej_valid, 1'b0);
        iv = '0;
        jv = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R4: every destination from the north link
        for (int d = 0; d < 16; d++) begin
            iv = 4'b0001;
            ifl[0] = mk(d % 4, d / 4, 5, 16'hA000 + d);
            tick("R4");
        end
        idle(2);

        // R5: equal ages, both east: north wins, south forced to north
        iv = 4'b0101;
        ifl[0] = mk(3, 2, 7, 1);
        ifl[2] = mk(3, 2, 7, 2);
        tick("R5");
        // R5: older south beats north for east
        ifl[0] = mk(3, 2, 7, 3);
        ifl[2] = mk(3, 2, 8, 4);
        tick("R5");
        // R5: injection loses against any transit flit
        iv = 4'b1000;
        ifl[3] = mk(3, 2, 0, 5);
        jv = 1'b1;
        jf = mk(3, 2, 200, 6);
        tick("R5");
        jv = 1'b0;
        // R3: 255 and 254 both saturate, tie goes to east over west
        iv = 4'b1010;
        ifl[1] = mk(3, 2, 254, 7);
        ifl[3] = mk(3, 2, 255, 8);
        tick("R3");
        // R7: two flits for this node, one ejects, one deflected
        iv = 4'b0011;
        ifl[0] = mk(1, 2, 3, 9);
        ifl[1] = mk(1, 2, 4, 10);
        tick("R7");
        // R8: full links with no local flit refuse injection
        iv = 4'b1111;
        for (int i = 0; i < 4; i++) ifl[i] = mk(3, 0, i, 20 + i);
        jv = 1'b1;
        jf = mk(0, 0, 0, 30);
        tick("R8");
        // R8: full links with one local flit accept injection
        ifl[2] = mk(1, 2, 9, 31);
        tick("R8");
        // R8: three links busy accept injection
        iv = 4'b0111;
        tick("R8");
        idle(2);

        // sweep: every node position, every occupancy mask
        for (int node = 0; node < 16; node++) begin
            nx = 2'(node % 4);
            ny = 2'(node / 4);
            for (int k = 0; k < 320; k++) begin
                int unsigned r;
                iv = 4'(k % 32);
                jv = (k % 32) >= 16;
                for (int i = 0; i < 4; i++) begin
                    r = nxt_rand();
                    ifl[i] = mk(int'(r % 4), int'((r >> 4) % 4), pick_age(r >> 8),
                                (node << 16) | (k << 4) | i);
                end
                r = nxt_rand();
                jf = mk(int'(r % 4), int'((r >> 4) % 4), int'((r >> 8) % 256),
                        (node << 16) | (k << 4) | 4);
                tick("R6");
            end
            idle(2);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule